// File: doc/BRIEF.md
# Halt-Aware Cycle Counter

This block measures how many clock cycles a pipelined processor needs to run a program. A 16-bit counter starts at zero when reset is released and goes up by one every clock. When the decode stage presents the halt opcode with its valid flag high, the count freezes. It stays frozen until the next reset, so the run time can be read at leisure.

The decode-stage opcode arrives as a stream with a valid qualifier. The counter samples it on every clock and never applies back-pressure, so no ready signal exists. When valid is low, the opcode bits are ignored. A display-select switch passes straight through to an output. The top level uses that output to decide whether the seven-segment digits show the count.

Top module: `cyc_perf_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cycle_count` becomes 0 and `halted` becomes 0 at that edge.
- R2: At each rising edge with `rst` low and `halted` low, where the decode input does not hold a valid halt, `cycle_count` increases by exactly one.
- R3: At a rising edge where `dec_valid` is 1, `dec_opcode` is 8'h01 (halt) and `halted` is 0, `cycle_count` keeps its value and `halted` becomes 1.
- R4: A valid no-operation opcode 8'h0A leaves `halted` at 0 and lets the count advance by one, as in R2.
- R5: When `dec_valid` is 0, the value on `dec_opcode` has no effect, including 8'h01.
- R6: Once `halted` is 1, it stays 1 and `cycle_count` holds its value on every edge until reset, whatever opcodes arrive.
- R7: When `cycle_count` is 16'hFFFF and it advances under R2, it becomes 16'h0000.
- R8: `disp_show` equals `disp_sel` at all times, with no clock delay.
- R9: Any valid opcode other than 8'h01 behaves like R2 and does not stop counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_opcode | input | 8 | Opcode held in the decode stage |
| dec_valid | input | 1 | Qualifies `dec_opcode` |
| disp_sel | input | 1 | Display-select switch |
| cycle_count | output | 16 | Current cycle count |
| halted | output | 1 | Sticky halt flag |
| disp_show | output | 1 | Display-select passthrough |

## Verification
The hardest case to reach is the wrap from 16'hFFFF to zero. It needs 65535 consecutive cycles without a halt. The stimulus gets there by holding reset off and feeding a long random stream of valid and invalid opcodes, all different from 8'h01. It then checks the count just before the wrap and just after it. A second hard case is a halt that arrives on the same edge as other activity. Random runs insert the halt at a random cycle. After the halt, they keep sending random opcodes, including further halts, nops and invalid slots, to show that the frozen value never moves.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int OP_W  = 8;
  localparam int CNT_W = 16;
  localparam logic [OP_W-1:0] OP_HALT = 8'h01;
  localparam logic [OP_W-1:0] OP_NOP  = 8'h0A;
endpackage

// File: rtl/cpc_opdecode.sv
module cpc_opdecode
  import cpc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic            valid,
  output logic            halt_hit,
  output logic            nop_hit
);
  always_comb begin
    halt_hit = valid && (opcode == OP_HALT);
    nop_hit  = valid && (opcode == OP_NOP);
  end
endmodule

// File: rtl/cpc_halt_latch.sv
module cpc_halt_latch (
  input  logic clk,
  input  logic rst,
  input  logic halt_hit,
  output logic halted
);
  always_ff @(posedge clk) begin
    if (rst)           halted <= 1'b0;
    else if (halt_hit) halted <= 1'b1;
  end

  // R6
  sticky_halt_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R3
  halt_set_chk: assert property (@(posedge clk) disable iff (rst)
    halt_hit |=> halted);
endmodule

// File: rtl/cpc_tick_counter.sv
module cpc_tick_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (run) cnt <= cnt + ONE;
  end

  // R1
  cnt_clear_chk: assert property (@(posedge clk) rst |=> (cnt == '0));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt == $past(cnt) + ONE));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));
endmodule

// File: rtl/cyc_perf_counter.sv
module cyc_perf_counter
  import cpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  dec_opcode,
  input  logic             dec_valid,
  input  logic             disp_sel,
  output logic [CNT_W-1:0] cycle_count,
  output logic             halted,
  output logic             disp_show
);
  logic halt_hit;
  logic nop_hit;
  logic run;

  cpc_opdecode u_dec (
    .opcode   (dec_opcode),
    .valid    (dec_valid),
    .halt_hit (halt_hit),
    .nop_hit  (nop_hit)
  );

  cpc_halt_latch u_halt (
    .clk      (clk),
    .rst      (rst),
    .halt_hit (halt_hit),
    .halted   (halted)
  );

  assign run = !halted && !halt_hit;

  cpc_tick_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .run (run),
    .cnt (cycle_count)
  );

  assign disp_show = disp_sel;

  // R4
  nop_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (nop_hit && !halted) |=> (!halted && cycle_count == $past(cycle_count) + CNT_W'(1)));

  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_hit && !halted) |=> $stable(cycle_count));

  // R5
  invalid_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!dec_valid && !halted) |=> !halted);
endmodule

// File: tb/cyc_perf_counter_test.sv
`timescale 1ns/1ps
module cyc_perf_counter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  dec_opcode;
  logic        dec_valid;
  logic        disp_sel;
  logic [15:0] cycle_count;
  logic        halted;
  logic        disp_show;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_cnt;
  logic        m_halt;
  bit          done = 0;

  always #4 clk = ~clk;

  cyc_perf_counter uut (
    .clk(clk), .rst(rst), .dec_opcode(dec_opcode), .dec_valid(dec_valid),
    .disp_sel(disp_sel), .cycle_count(cycle_count), .halted(halted),
    .disp_show(disp_show)
  );

  function automatic logic is_halt(logic [7:0] op, logic v);
    return v && (op == 8'h01);
  endfunction

  function automatic logic [15:0] next_cnt(logic [15:0] c, logic h, logic [7:0] op, logic v);
    if (h || is_halt(op, v)) return c;
    return c + 16'd1;
  endfunction

  task automatic check(string req, logic [15:0] act_c, logic [15:0] exp_c,
                       logic act_h, logic exp_h);
    n_chk++;
    if (act_c !== exp_c || act_h !== exp_h) begin
      n_bad++;
      $display("FAIL %s: count=%h halted=%b expected count=%h halted=%b",
               req, act_c, act_h, exp_c, exp_h);
    end
  endtask

  task automatic tick(logic [7:0] op, logic v, logic r, string req, bit chk);
    dec_opcode = op; dec_valid = v; rst = r;
    @(posedge clk);
    if (r) begin m_cnt = '0; m_halt = 1'b0; end
    else begin
      m_cnt  = next_cnt(m_cnt, m_halt, op, v);
      m_halt = m_halt | is_halt(op, v);
    end
    @(negedge clk);
    if (chk) check(req, cycle_count, m_cnt, halted, m_halt);
  endtask

  function automatic logic [7:0] rand_nonhalt();
    logic [7:0] o;
    o = 8'($urandom);
    if (o == 8'h01) o = 8'h0A;
    return o;
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    m_cnt = 'x; m_halt = 'x;
    dec_opcode = 8'h00; dec_valid = 1'b0; disp_sel = 1'b0; rst = 1'b1;
    @(negedge clk);
    tick(8'h00, 1'b0, 1'b1, "R1", 1);
    tick(8'h01, 1'b1, 1'b1, "R1", 1);

    // R2 / R4 / R9 directed
    tick(8'h0A, 1'b1, 1'b0, "R4", 1);
    tick(8'h0A, 1'b1, 1'b0, "R4", 1);
    tick(8'h33, 1'b1, 1'b0, "R9", 1);
    tick(8'h00, 1'b1, 1'b0, "R9", 1);
    // R5: halt code with valid low
    tick(8'h01, 1'b0, 1'b0, "R5", 1);
    tick(8'h01, 1'b0, 1'b0, "R5", 1);
    // R3: halt
    tick(8'h01, 1'b1, 1'b0, "R3", 1);
    // R6: sticky
    tick(8'h0A, 1'b1, 1'b0, "R6", 1);
    tick(8'h01, 1'b1, 1'b0, "R6", 1);
    tick(8'h55, 1'b0, 1'b0, "R6", 1);
    // R1 clears after halt
    tick(8'h00, 1'b0, 1'b1, "R1", 1);

    // R8 display passthrough
    for (int i = 0; i < 8; i++) begin
      disp_sel = 1'($urandom);
      #1;
      n_chk++;
      if (disp_show !== disp_sel) begin
        n_bad++;
        $display("FAIL R8: disp_show=%b expected %b", disp_show, disp_sel);
      end
    end

    // Random rounds: R2, R3, R5, R6, R9
    for (int rnd = 0; rnd < 6; rnd++) begin
      int stop_at;
      tick(8'h00, 1'b0, 1'b1, "R1", 1);
      stop_at = 5 + int'($urandom % 40);
      for (int k = 0; k < stop_at; k++)
        tick(rand_nonhalt(), 1'($urandom), 1'b0, "R2", 1);
      tick(8'h01, 1'b1, 1'b0, "R3", 1);
      for (int k = 0; k < 20; k++)
        tick(8'($urandom % 16), 1'($urandom), 1'b0, "R6", 1);
    end

    // R7 wrap: 65535 advancing cycles, then one more
    tick(8'h00, 1'b0, 1'b1, "R1", 1);
    for (int k = 0; k < 65534; k++)
      tick(rand_nonhalt(), 1'($urandom), 1'b0, "R2", 0);
    tick(8'h0A, 1'b1, 1'b0, "R7", 1);
    check("R7", cycle_count, 16'hFFFF, halted, 1'b0);
    tick(8'h0A, 1'b1, 1'b0, "R7", 1);
    check("R7", cycle_count, 16'h0000, halted, 1'b0);
    tick(8'h77, 1'b1, 1'b0, "R7", 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule